// File: doc/BRIEF.md
# Three-Stage Pipelined Microoperation Datapath

This block runs a stream of register-transfer microoperations through a register file and a function unit. Each microoperation is presented as a set of control fields on one cycle: two source register addresses, a destination address, a function code, a constant-versus-register choice for the second operand, a result-versus-external-data choice for write-back, a write enable and a valid flag. Pipeline registers split the work into three stages. In the fetch stage the register file is read. In the execute stage the function unit computes a result. In the write-back stage the register file is written. A new microoperation can enter on every clock.

Each control field travels with its data to the stage that consumes it. The function code reaches execute, while the destination, the write-back source choice and the write enable reach write-back. The constant operand is captured at fetch. The execute-stage operands are driven out as an address and a data word for an attached memory, together with four status flags. Data returned by that memory is taken on the write-back cycle, two cycles after issue. The block has no hazard detection and no forwarding. The issuing controller must space dependent operations itself.

Top module: `uop_pipe_datapath`

## Requirements
- R1: The block accepts one microoperation per cycle. An operation issued in cycle t writes its destination at the end of cycle t+2. A read issued in cycle t+3 or later returns the new value.
- R2: During cycle t+1, `addr_out` shows the register selected by `cw_src_a` as read in cycle t. `data_out` shows `const_in` sampled in cycle t when `cw_sel_const` is 1, and otherwise the register selected by `cw_src_b`.
- R3: During the execute cycle the flags describe the result F. `st_zero` is 1 when F is all zeros. `st_neg` is the top bit of F. `st_carry` is the adder carry out. `st_ovf` is 1 when both adder inputs share a sign that differs from the sign of F. Carry and overflow are 0 for the logic and shift codes.
- R4: Function codes 0 to 7 compute A + X + c, where c is bit 0 of the code. X is selected by code bits 2:1: 00 gives zero, 01 gives B, 10 gives the complement of B, and 11 gives all ones. This yields pass A, increment, add, add plus one, add complement, subtract, decrement, and pass A with carry.
- R5: The remaining function codes are: 8 is A AND B, 9 is A OR B, 10 is A XOR B, 11 is NOT A, 12 is pass B, 13 is B shifted right by one with a zero entering, 14 is B shifted left by one with a zero entering, and 15 is B rotated left by one.
- R6: At write-back, the value written is `data_in` sampled in the write-back cycle (t+2) when `cw_sel_in` was 1 at issue, and otherwise the function-unit result.
- R7: An operation issued with `cw_valid` at 0 or with `cw_wr_en` at 0 leaves every register unchanged. This includes the bubbles present while the pipeline fills after reset.
- R8: No forwarding is done. A read issued one or two cycles after a write to the same register returns the value held before that write.
- R9: After reset every register holds zero. The pipeline is empty, and `addr_out` and `data_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_valid | input | 1 | Microoperation present this cycle |
| cw_dst | input | AW | Destination register |
| cw_src_a | input | AW | Register read onto operand A |
| cw_src_b | input | AW | Register read onto operand B |
| cw_sel_const | input | 1 | 1: operand B is `const_in` |
| cw_func | input | 4 | Function code |
| cw_sel_in | input | 1 | 1: write back `data_in` instead of the result |
| cw_wr_en | input | 1 | Write the destination at write-back |
| const_in | input | W | Constant operand, sampled at issue |
| data_in | input | W | External data, sampled at write-back |
| addr_out | output | W | Execute-stage operand A |
| data_out | output | W | Execute-stage operand B |
| st_zero | output | 1 | Result is zero |
| st_neg | output | 1 | Result sign bit |
| st_carry | output | 1 | Adder carry out |
| st_ovf | output | 1 | Signed overflow |

## Verification
The hardest situation to reach from the ports is a read that lands in the two-cycle window before a pending write completes. Random traffic rarely hits this window with a known expected value. Directed chains therefore issue an increment of a register and then read the same register in each of the next three cycles. Only the third read may see the new value.

A second difficulty is that `data_in` belongs to the operation issued two cycles earlier, not to the current one. The stimulus supplies fresh external data every cycle. A bench-side three-stage model pairs each value with the operation then in write-back, so a one-cycle skew shows up as wrong values on later reads.

// File: rtl/upd_pkg.sv
package upd_pkg;

    localparam int FN_W = 4;

    typedef enum logic [FN_W-1:0] {
        FN_PASS_A   = 4'd0,
        FN_INC_A    = 4'd1,
        FN_ADD      = 4'd2,
        FN_ADD_P1   = 4'd3,
        FN_ADD_NB   = 4'd4,
        FN_SUB      = 4'd5,
        FN_DEC_A    = 4'd6,
        FN_PASS_A_C = 4'd7,
        FN_AND      = 4'd8,
        FN_OR       = 4'd9,
        FN_XOR      = 4'd10,
        FN_NOT_A    = 4'd11,
        FN_PASS_B   = 4'd12,
        FN_SHR_B    = 4'd13,
        FN_SHL_B    = 4'd14,
        FN_ROL_B    = 4'd15
    } fn_code_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic carry;
        logic ovf;
    } status_t;

endpackage

// File: rtl/upd_regfile.sv
module upd_regfile #(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_addr,
    input  logic [AW-1:0] rd_b_addr,
    output logic [W-1:0]  rd_a_data,
    output logic [W-1:0]  rd_b_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);

    localparam int NREG = 1 << AW;

    logic [W-1:0]    regs [NREG];
    logic [NREG-1:0] wr_sel;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_wdec
        assign wr_sel[gi] = wr_en && (wr_addr == AW'(gi));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_sel[i]) regs[i] <= wr_data;
            end
        end
    end

    // Reads see the contents before any write of the same edge.
    assign rd_a_data = regs[rd_a_addr];
    assign rd_b_data = regs[rd_b_addr];

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel)); // R7

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs[$past(wr_addr)] == $past(wr_data)); // R1

endmodule

// File: rtl/upd_func_unit.sv
module upd_func_unit
    import upd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]    op_a,
    input  logic [W-1:0]    op_b,
    input  logic [FN_W-1:0] fn,
    output logic [W-1:0]    result,
    output status_t         status
);

    logic [W-1:0] add_x;
    logic [W:0]   sum;
    logic         cin;
    logic         ovf_raw;

    // Adder operand select for the arithmetic half of the code space.
    always_comb begin
        unique case (fn[2:1])
            2'b00: add_x = '0;
            2'b01: add_x = op_b;
            2'b10: add_x = ~op_b;
            2'b11: add_x = '1;
        endcase
        cin     = fn[0];
        sum     = {1'b0, op_a} + {1'b0, add_x} + {{W{1'b0}}, cin};
        ovf_raw = (op_a[W-1] == add_x[W-1]) && (sum[W-1] != op_a[W-1]);
    end

    always_comb begin
        result       = '0;
        status.carry = 1'b0;
        status.ovf   = 1'b0;
        if (!fn[3]) begin
            result       = sum[W-1:0];
            status.carry = sum[W];
            status.ovf   = ovf_raw;
        end else begin
            unique case (fn_code_e'(fn))
                FN_AND:    result = op_a & op_b;
                FN_OR:     result = op_a | op_b;
                FN_XOR:    result = op_a ^ op_b;
                FN_NOT_A:  result = ~op_a;
                FN_PASS_B: result = op_b;
                FN_SHR_B:  result = {1'b0, op_b[W-1:1]};
                FN_SHL_B:  result = {op_b[W-2:0], 1'b0};
                FN_ROL_B:  result = {op_b[W-2:0], op_b[W-1]};
                default:   result = sum[W-1:0];
            endcase
        end
        status.zero = (result == '0);
        status.neg  = result[W-1];
    end

endmodule

// File: rtl/uop_pipe_datapath.sv
module uop_pipe_datapath
    import upd_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cw_valid,
    input  logic [AW-1:0] cw_dst,
    input  logic [AW-1:0] cw_src_a,
    input  logic [AW-1:0] cw_src_b,
    input  logic          cw_sel_const,
    input  logic [3:0]    cw_func,
    input  logic          cw_sel_in,
    input  logic          cw_wr_en,
    input  logic [W-1:0]  const_in,
    input  logic [W-1:0]  data_in,
    output logic [W-1:0]  addr_out,
    output logic [W-1:0]  data_out,
    output logic          st_zero,
    output logic          st_neg,
    output logic          st_carry,
    output logic          st_ovf
);

    // Execute-stage pipeline register: operands plus fields still needed.
    typedef struct packed {
        logic            valid;
        logic [W-1:0]    a;
        logic [W-1:0]    b;
        logic [FN_W-1:0] fn;
        logic [AW-1:0]   dst;
        logic            sel_in;
        logic            wr_en;
    } ex_stage_t;

    // Write-back pipeline register: result and write controls.
    typedef struct packed {
        logic          valid;
        logic [W-1:0]  f;
        logic [AW-1:0] dst;
        logic          sel_in;
        logic          wr_en;
    } wb_stage_t;

    ex_stage_t    ex_q;
    wb_stage_t    wb_q;
    logic [W-1:0] rf_a;
    logic [W-1:0] rf_b;
    logic [W-1:0] bus_b;
    logic [W-1:0] fu_f;
    status_t      fu_st;
    logic         rf_we;
    logic [W-1:0] rf_wd;

    // ---------------- operand fetch ----------------
    upd_regfile #(.W(W), .AW(AW)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_addr (cw_src_a),
        .rd_b_addr (cw_src_b),
        .rd_a_data (rf_a),
        .rd_b_data (rf_b),
        .wr_en     (rf_we),
        .wr_addr   (wb_q.dst),
        .wr_data   (rf_wd)
    );

    assign bus_b = cw_sel_const ? const_in : rf_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_q <= '0;
        end else begin
            ex_q.valid  <= cw_valid;
            ex_q.a      <= rf_a;
            ex_q.b      <= bus_b;
            ex_q.fn     <= cw_func;
            ex_q.dst    <= cw_dst;
            ex_q.sel_in <= cw_sel_in;
            ex_q.wr_en  <= cw_wr_en;
        end
    end

    // ---------------- execute ----------------
    upd_func_unit #(.W(W)) u_fu (
        .op_a   (ex_q.a),
        .op_b   (ex_q.b),
        .fn     (ex_q.fn),
        .result (fu_f),
        .status (fu_st)
    );

    assign addr_out = ex_q.a;
    assign data_out = ex_q.b;
    assign st_zero  = fu_st.zero;
    assign st_neg   = fu_st.neg;
    assign st_carry = fu_st.carry;
    assign st_ovf   = fu_st.ovf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else begin
            wb_q.valid  <= ex_q.valid;
            wb_q.f      <= fu_f;
            wb_q.dst    <= ex_q.dst;
            wb_q.sel_in <= ex_q.sel_in;
            wb_q.wr_en  <= ex_q.wr_en;
        end
    end

    // ---------------- write-back ----------------
    assign rf_we = wb_q.valid && wb_q.wr_en;
    assign rf_wd = wb_q.sel_in ? data_in : wb_q.f;

    AST_WB_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(cw_valid && cw_wr_en, 2)); // R7

    AST_WB_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (wb_q.dst == $past(cw_dst, 2))); // R1

    AST_CONST_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cw_sel_const)) |-> (data_out == $past(const_in))); // R2

    AST_LOGIC_NO_CV: assert property (@(posedge clk) disable iff (!rst_n)
        ex_q.fn[3] |-> (!st_carry && !st_ovf)); // R5

    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        st_zero |-> !st_neg); // R3

endmodule

// File: tb/uop_pipe_datapath_bench.sv
`timescale 1ns/1ps
module uop_pipe_datapath_bench;

    localparam int W  = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cw_valid = 1'b0;
    logic [AW-1:0] cw_dst = '0, cw_src_a = '0, cw_src_b = '0;
    logic          cw_sel_const = 1'b0, cw_sel_in = 1'b0, cw_wr_en = 1'b0;
    logic [3:0]    cw_func = '0;
    logic [W-1:0]  const_in = '0, data_in = '0;
    logic [W-1:0]  addr_out, data_out;
    logic          st_zero, st_neg, st_carry, st_ovf;

    always #5 clk = ~clk;

    uop_pipe_datapath #(.W(W), .AW(AW)) u_uop_pipe_datapath (
        .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_dst(cw_dst),
        .cw_src_a(cw_src_a), .cw_src_b(cw_src_b), .cw_sel_const(cw_sel_const),
        .cw_func(cw_func), .cw_sel_in(cw_sel_in), .cw_wr_en(cw_wr_en),
        .const_in(const_in), .data_in(data_in), .addr_out(addr_out),
        .data_out(data_out), .st_zero(st_zero), .st_neg(st_neg),
        .st_carry(st_carry), .st_ovf(st_ovf)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string tag_ovr = "";

    // Bench model of the register file and the two pipeline registers.
    logic [W-1:0] m_rf [8];
    bit           mx_v;
    logic [W-1:0] mx_a, mx_b;
    logic [3:0]   mx_fn;
    int           mx_dst;
    bit           mx_md, mx_rw;
    bit           mw_v;
    logic [W-1:0] mw_f;
    int           mw_dst;
    bit           mw_md, mw_rw;

    // Returns {zero, neg, carry, ovf, result}.
    function automatic logic [11:0] ref_fu(input logic [3:0] fn,
                                           input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        logic [7:0] x;
        logic [7:0] f;
        bit c, v, arith;
        arith = 1'b1;
        x = 8'h00;
        s = 9'h000;
        case (fn)
            4'd0:  begin x = 8'h00; s = a + 9'd0; end
            4'd1:  begin x = 8'h00; s = a + 9'd1; end
            4'd2:  begin x = b;     s = a + b; end
            4'd3:  begin x = b;     s = a + b + 9'd1; end
            4'd4:  begin x = ~b;    s = a + {1'b0, ~b}; end
            4'd5:  begin x = ~b;    s = a + {1'b0, ~b} + 9'd1; end
            4'd6:  begin x = 8'hFF; s = a + 9'h0FF; end
            4'd7:  begin x = 8'hFF; s = a + 9'h0FF + 9'd1; end
            default: arith = 1'b0;
        endcase
        if (arith) begin
            f = s[7:0];
            c = s[8];
            v = (a[7] == x[7]) && (f[7] != a[7]);
        end else begin
            c = 1'b0;
            v = 1'b0;
            case (fn)
                4'd8:    f = a & b;
                4'd9:    f = a | b;
                4'd10:   f = a ^ b;
                4'd11:   f = ~a;
                4'd12:   f = b;
                4'd13:   f = b >> 1;
                4'd14:   f = b << 1;
                default: f = {b[6:0], b[7]};
            endcase
        end
        return {(f == 8'h00), f[7], c, v, f};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check the execute stage, advance the model.
    task automatic step(input bit v, input int dst, input int sa, input int sb,
                        input bit mb, input logic [3:0] fn, input bit md, input bit rw,
                        input logic [7:0] k, input logic [7:0] din);
        logic [11:0] r;
        string t;
        cw_valid = v; cw_dst = AW'(dst); cw_src_a = AW'(sa); cw_src_b = AW'(sb);
        cw_sel_const = mb; cw_func = fn; cw_sel_in = md; cw_wr_en = rw;
        const_in = k; data_in = din;
        #1;
        r = ref_fu(mx_fn, mx_a, mx_b);
        if (mx_v) begin
            t = (tag_ovr != "") ? tag_ovr : "R2";
            check(t, {addr_out, data_out}, {mx_a, mx_b});
            t = (tag_ovr != "") ? tag_ovr : (mx_fn[3] ? "R5" : "R4");
            check(t, {12'h000, st_zero, st_neg, st_carry, st_ovf}, {12'h000, r[11:8]});
        end
        // advance model: fetch reads old contents, then write-back lands
        mw_v = mx_v; mw_f = r[7:0]; mw_dst = mx_dst; mw_md = mx_md; mw_rw = mx_rw;
        mx_v = v; mx_a = m_rf[sa]; mx_b = mb ? k : m_rf[sb];
        mx_fn = fn; mx_dst = dst; mx_md = md; mx_rw = rw;
        @(posedge clk);
        if (prev_we) m_rf[prev_dst] = prev_wd;
        @(negedge clk);
    endtask

    // Write-back pending from the previous model stage, applied at the edge.
    bit           prev_we;
    int           prev_dst;
    logic [W-1:0] prev_wd;
    always @(posedge clk) begin end

    task automatic stepw(input bit v, input int dst, input int sa, input int sb,
                         input bit mb, input logic [3:0] fn, input bit md, input bit rw,
                         input logic [7:0] k, input logic [7:0] din);
        prev_we  = mw_v && mw_rw;
        prev_dst = mw_dst;
        prev_wd  = mw_md ? din : mw_f;
        step(v, dst, sa, sb, mb, fn, md, rw, k, din);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) stepw(0, 0, 0, 0, 0, 4'd0, 0, 0, 8'h00, 8'h00);
    endtask

    task automatic read_all();
        for (int i = 0; i < 8; i++) stepw(1, 0, i, 7 - i, 0, 4'd0, 0, 0, 8'h00, 8'h00);
        idle(2);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_rf[i] = '0;
        mx_v = 0; mx_a = 0; mx_b = 0; mx_fn = 0; mx_dst = 0; mx_md = 0; mx_rw = 0;
        mw_v = 0; mw_f = 0; mw_dst = 0; mw_md = 0; mw_rw = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: empty pipeline after reset, zeroed outputs and registers
        #1;
        check("R9", {addr_out, data_out}, 16'h0000);
        check("R9", {12'h000, st_zero, st_neg, st_carry, st_ovf}, 16'h0008);
        tag_ovr = "R9";
        read_all();

        // R6: load every register from external data, two cycles after issue
        tag_ovr = "R6";
        for (int i = 0; i < 8; i++)
            stepw(1, i, 0, 0, 0, 4'd0, 1, 1, 8'h00, 8'(8'h35 + i * 8'h11));
        stepw(0, 0, 0, 0, 0, 4'd0, 0, 0, 8'h00, 8'(8'h35 + 8 * 8'h11));
        stepw(0, 0, 0, 0, 0, 4'd0, 0, 0, 8'h00, 8'(8'h35 + 9 * 8'h11));
        read_all();

        // R8: increment R1 and read it in the three following cycles
        tag_ovr = "R8";
        stepw(1, 1, 1, 0, 0, 4'd1, 0, 1, 8'h00, 8'h00);
        stepw(1, 0, 1, 0, 0, 4'd0, 0, 0, 8'h00, 8'h00);
        stepw(1, 0, 1, 0, 0, 4'd0, 0, 0, 8'h00, 8'h00);
        stepw(1, 0, 1, 0, 0, 4'd0, 0, 0, 8'h00, 8'h00);
        idle(2);

        // R3: overflow, carry and zero corner cases
        tag_ovr = "R3";
        stepw(1, 2, 0, 0, 0, 4'd0, 1, 1, 8'h00, 8'h00);
        idle(1);
        stepw(0, 0, 0, 0, 0, 4'd0, 0, 0, 8'h00, 8'h7F);
        stepw(1, 3, 2, 0, 1, 4'd2, 0, 1, 8'h01, 8'h00);
        stepw(1, 4, 2, 0, 1, 4'd5, 0, 1, 8'h7F, 8'h00);
        stepw(1, 5, 2, 0, 1, 4'd5, 0, 1, 8'h80, 8'h00);
        stepw(1, 6, 2, 0, 1, 4'd6, 0, 1, 8'h00, 8'h00);
        idle(2);
        read_all();

        // R7: invalid slots and disabled writes leave registers intact
        tag_ovr = "R7";
        stepw(0, 3, 0, 0, 1, 4'd12, 0, 1, 8'hA5, 8'h00);
        stepw(1, 4, 0, 0, 1, 4'd12, 0, 0, 8'h5A, 8'h00);
        stepw(0, 5, 0, 0, 0, 4'd0, 1, 1, 8'h00, 8'h00);
        idle(2);
        read_all();

        // R1: continuous issue, each register rewritten and read back three later
        tag_ovr = "R1";
        for (int i = 0; i < 24; i++)
            stepw(1, i % 8, (i + 5) % 8, i % 8, 0, 4'd3, 0, 1, 8'h00, 8'h00);
        idle(2);
        read_all();

        // R2/R4/R5: constrained random traffic
        tag_ovr = "";
        for (int i = 0; i < 600; i++) begin
            stepw(($urandom % 5) != 0, int'($urandom % 8), int'($urandom % 8),
                  int'($urandom % 8), ($urandom % 3) == 0, 4'($urandom),
                  ($urandom % 4) == 0, ($urandom % 4) != 0,
                  8'($urandom), 8'($urandom));
        end
        idle(2);
        tag_ovr = "R1";
        read_all();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule